// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Line Decoder

This block turns the two single-ended USB data lines into a stream of decoded data bits. An oversampling clock samples D+ and D-. The samples pass through a two-flop synchroniser, and each one is classified as a line state: J, K, SE0 or SE1. A speed-select input picks full-speed or low-speed operation. The choice sets how many clocks make one bit time and which line polarity counts as J.

While the line is idle, a J-to-K change marks the start of a packet. From that edge an integer counter places each sample point in the middle of its bit: the first sample comes half a bit time after the edge, and every later sample follows one whole bit time after the one before. Later edges do not resynchronise the counter. Each sampled symbol is NRZI-decoded against the previous one. A zero that follows six consecutive ones is flagged as a stuffed bit and is not delivered as data. An SE0 during reception starts end-of-packet handling, and a J sampled after the SE0 completes it. Protocol violations give an error pulse and send the block back to idle. Sync-pattern, PID and CRC checking belong to later stages.

Top module: `usb_rx_decoder`

## Requirements
- R1: Line state is classified from the pair {D+, D-}: 00 is SE0 and 11 is SE1. At full speed, 10 is J and 01 is K. At low speed, 01 is J and 10 is K.
- R2: A classified J followed directly by K while idle gives exactly one `sop_o` pulse. Line changes after that do not give another `sop_o` until the block has returned to idle.
- R3: The first sample result (`bit_valid_o` or `stuff_o`) comes CPB/2 clocks after `sop_o`. Each later one comes exactly CPB clocks after the one before, where CPB is the clocks-per-bit parameter of the selected speed.
- R4: NRZI decoding: a sampled symbol equal to the previous symbol gives data 1, and a different one gives data 0. The first bit of a packet is compared against J.
- R5: A 0 that follows six consecutive decoded 1s pulses `stuff_o` instead of `bit_valid_o`, and the count of consecutive ones returns to zero.
- R6: An SE0 sample during reception, followed by further SE0 samples and then a J sample, gives one `eop_o` pulse and returns the block to idle.
- R7: Any of these pulses `err_o` once, returns the block to idle and gives no `eop_o`: a seventh consecutive 1, an SE1 sample during reception, or a K or SE1 sample during end-of-packet handling.
- R8: After reset all output pulses are low and the block is idle. At most one of `bit_valid_o`, `stuff_o`, `sop_o`, `eop_o` and `err_o` is high in any cycle.
- R9: `low_speed_i` high selects the low-speed bit time and polarity. It is changed only while the line is in SE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| low_speed_i | input | 1 | 1 selects low speed, 0 selects full speed |
| bit_valid_o | output | 1 | One-cycle strobe: `bit_o` carries a decoded data bit |
| bit_o | output | 1 | Decoded data bit |
| stuff_o | output | 1 | One-cycle pulse: a stuffed bit was removed |
| sop_o | output | 1 | One-cycle pulse: start of packet detected |
| eop_o | output | 1 | One-cycle pulse: end of packet completed |
| err_o | output | 1 | One-cycle pulse: protocol violation, block returned to idle |

## Verification
The hardest state to reach is the one where the ones counter stands at six and the next symbol decides between a stuffed bit, a seventh-one error and the start of end-of-packet. A legal packet gets there only with long runs of ones at exactly the right bit positions. The stimulus reaches it in three ways: all-ones payload bytes, random bytes whose stuffing the bench computes itself, and raw symbol streams that skip stuffing on purpose. The SE1 and K-during-end-of-packet violations are likewise driven as raw symbol sequences after a valid sync pattern, in both speed modes.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'd0,
    SYM_J   = 2'd1,
    SYM_K   = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_EOP  = 2'd2
  } rx_state_e;

  localparam int unsigned MAX_ONES = 6;
endpackage

// File: rtl/usb_rx_sync.sv
module usb_rx_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/usb_rx_linestate.sv
module usb_rx_linestate
  import usb_rx_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      low_speed_i,
  output line_sym_e sym_o
);
  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   sym_o = SYM_SE0;
      2'b11:   sym_o = SYM_SE1;
      2'b10:   sym_o = low_speed_i ? SYM_K : SYM_J;
      default: sym_o = low_speed_i ? SYM_J : SYM_K;
    endcase
  end
endmodule

// File: rtl/usb_rx_core.sv
module usb_rx_core
  import usb_rx_pkg::*;
#(
  parameter int unsigned CPB_FS = 4,
  parameter int unsigned CPB_LS = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_sym_e sym_i,
  input  logic      low_speed_i,
  output logic      bit_valid_o,
  output logic      bit_o,
  output logic      stuff_o,
  output logic      sop_o,
  output logic      eop_o,
  output logic      err_o
);
  localparam int unsigned CPB_MAX = (CPB_LS > CPB_FS) ? CPB_LS : CPB_FS;
  localparam int unsigned CW      = $clog2(CPB_MAX + 1);
  localparam int unsigned OW      = $clog2(MAX_ONES + 2);

  rx_state_e       state_q, state_d;
  line_sym_e       line_q, prev_q, prev_d;
  logic [CW-1:0]   cnt_q, cnt_d, reload, half;
  logic [OW-1:0]   ones_q, ones_d;
  logic            v_d, b_d, st_d, sop_d, eop_d, err_d, same;

  assign reload = low_speed_i ? CW'(CPB_LS - 1)     : CW'(CPB_FS - 1);
  assign half   = low_speed_i ? CW'(CPB_LS / 2 - 1) : CW'(CPB_FS / 2 - 1);
  assign same   = (sym_i == prev_q);

  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    cnt_d   = cnt_q;
    ones_d  = ones_q;
    v_d     = 1'b0;
    b_d     = 1'b0;
    st_d    = 1'b0;
    sop_d   = 1'b0;
    eop_d   = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (line_q == SYM_J && sym_i == SYM_K) begin
          sop_d   = 1'b1;
          state_d = ST_BIT;
          cnt_d   = half;
        end
      end
      ST_BIT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end else begin
          cnt_d = reload;
          unique case (sym_i)
            SYM_SE0: state_d = ST_EOP;
            SYM_SE1: begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
            default: begin
              prev_d = sym_i;
              if (!same && ones_q == OW'(MAX_ONES)) begin
                st_d   = 1'b1;
                ones_d = '0;
              end else if (same && ones_q == OW'(MAX_ONES)) begin
                err_d   = 1'b1;
                state_d = ST_IDLE;
              end else if (same) begin
                v_d    = 1'b1;
                b_d    = 1'b1;
                ones_d = ones_q + OW'(1);
              end else begin
                v_d    = 1'b1;
                ones_d = '0;
              end
            end
          endcase
        end
      end
      ST_EOP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end else begin
          cnt_d = reload;
          unique case (sym_i)
            SYM_SE0: state_d = ST_EOP;
            SYM_J: begin
              eop_d   = 1'b1;
              state_d = ST_IDLE;
            end
            default: begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // leaving reception: NRZI reference back to idle J, run length cleared
    if (state_d == ST_IDLE) begin
      prev_d = SYM_J;
      ones_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      line_q      <= SYM_SE0;
      prev_q      <= SYM_J;
      cnt_q       <= '0;
      ones_q      <= '0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      stuff_o     <= 1'b0;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      line_q      <= sym_i;
      prev_q      <= prev_d;
      cnt_q       <= cnt_d;
      ones_q      <= ones_d;
      bit_valid_o <= v_d;
      bit_o       <= b_d;
      stuff_o     <= st_d;
      sop_o       <= sop_d;
      eop_o       <= eop_d;
      err_o       <= err_d;
    end
  end

  AST_SOP_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> ($past(state_q) == ST_IDLE && state_q == ST_BIT)); // R2
  AST_IDLE_REF_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (prev_q == SYM_J)); // R4
  AST_BIT_IN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> ($past(state_q) == ST_BIT)); // R4
  AST_ONES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OW'(MAX_ONES)); // R5
  AST_STUFF_AFTER_SIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_o |-> ($past(ones_q) == OW'(MAX_ONES) && ones_q == '0)); // R5
  AST_EOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> ($past(state_q) == ST_EOP && state_q == ST_IDLE)); // R6
  AST_ERR_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (state_q == ST_IDLE)); // R7
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_valid_o, stuff_o, sop_o, eop_o, err_o})); // R8
endmodule

// File: rtl/usb_rx_decoder.sv
module usb_rx_decoder
  import usb_rx_pkg::*;
#(
  parameter int unsigned CPB_FS = 4,
  parameter int unsigned CPB_LS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  input  logic low_speed_i,
  output logic bit_valid_o,
  output logic bit_o,
  output logic stuff_o,
  output logic sop_o,
  output logic eop_o,
  output logic err_o
);
  logic [1:0] pins_s;
  line_sym_e  sym;

  usb_rx_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_i, dm_i}),
    .q_o   (pins_s)
  );

  usb_rx_linestate u_class (
    .dp_i       (pins_s[1]),
    .dm_i       (pins_s[0]),
    .low_speed_i(low_speed_i),
    .sym_o      (sym)
  );

  usb_rx_core #(.CPB_FS(CPB_FS), .CPB_LS(CPB_LS)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sym_i      (sym),
    .low_speed_i(low_speed_i),
    .bit_valid_o(bit_valid_o),
    .bit_o      (bit_o),
    .stuff_o    (stuff_o),
    .sop_o      (sop_o),
    .eop_o      (eop_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/sim_usb_rx_decoder.sv
`timescale 1ns/1ps
module sim_usb_rx_decoder;
  localparam int FS = 4;
  localparam int LS = 32;
  localparam int S_SE0 = 0, S_J = 1, S_K = 2, S_SE1 = 3; // R1 encoding

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b0, ls = 1'b0;
  logic bv, bo, st, sop, eop, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_rx_decoder #(.CPB_FS(FS), .CPB_LS(LS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
    .bit_valid_o(bv), .bit_o(bo), .stuff_o(st), .sop_o(sop), .eop_o(eop), .err_o(err)
  );

  // monitor
  bit got_q[$];
  int n_sop, n_eop, n_err, n_stuff, since;
  bit first_ev, timing_bad;
  always @(negedge clk) begin
    since++;
    if (bv || st) begin
      if (since != (first_ev ? cpb()/2 : cpb())) timing_bad = 1'b1;
      first_ev = 1'b0;
      since = 0;
    end
    if (bv) got_q.push_back(bo);
    if (st) n_stuff++;
    if (sop) begin n_sop++; since = 0; first_ev = 1'b1; end
    if (eop) n_eop++;
    if (err) n_err++;
  end

  function automatic int cpb();
    return ls ? LS : FS;
  endfunction

  function automatic logic [1:0] pins(int s, bit low);
    case (s)
      S_SE0: return 2'b00;
      S_SE1: return 2'b11;
      S_J:   return low ? 2'b01 : 2'b10;
      default: return low ? 2'b10 : 2'b01;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int s, int nbits);
    @(negedge clk);
    {dp, dm} = pins(s, ls);
    repeat (nbits * cpb() - 1) @(negedge clk);
  endtask

  task automatic clear_mon();
    got_q.delete();
    n_sop = 0; n_eop = 0; n_err = 0; n_stuff = 0;
    timing_bad = 1'b0; first_ev = 1'b0; since = 0;
  endtask

  // encodes bits with stuffing (unless raw) and NRZI; returns symbol list
  function automatic void encode(bit bits[$], bit raw, ref int syms[$], ref int stuffs);
    int line = S_J;
    int ones = 0;
    stuffs = 0;
    foreach (bits[i]) begin
      if (bits[i]) begin
        ones++;
        syms.push_back(line);
        if (!raw && ones == 6) begin
          line = (line == S_J) ? S_K : S_J;
          syms.push_back(line);
          ones = 0;
          stuffs++;
        end
      end else begin
        line = (line == S_J) ? S_K : S_J;
        syms.push_back(line);
        ones = 0;
      end
    end
  endfunction

  task automatic set_speed(bit low);
    drive(S_SE0, 2);
    @(negedge clk);
    ls = low;
    drive(S_J, 4);
  endtask

  task automatic send_pkt(bit low, byte unsigned data[$], string tag);
    bit bits[$];
    int syms[$];
    int stuffs;
    bit match;
    if (ls != low) set_speed(low);
    for (int i = 0; i < 7; i++) bits.push_back(1'b0);
    bits.push_back(1'b1);
    foreach (data[i]) for (int j = 0; j < 8; j++) bits.push_back(data[i][j]);
    encode(bits, 1'b0, syms, stuffs);
    clear_mon();
    foreach (syms[i]) drive(syms[i], 1);
    drive(S_SE0, 2);
    drive(S_J, 4);
    match = (got_q.size() == bits.size());
    if (match) foreach (bits[i]) if (got_q[i] != bits[i]) match = 1'b0;
    check(match, {"R1/R4/R9 data ", tag}, got_q.size(), bits.size());
    check(n_stuff == stuffs, {"R5 stuff count ", tag}, n_stuff, stuffs);
    check(n_sop == 1, {"R2 sop count ", tag}, n_sop, 1);
    check(n_eop == 1, {"R6 eop count ", tag}, n_eop, 1);
    check(n_err == 0, {"R7 no error ", tag}, n_err, 0);
    check(!timing_bad, {"R3 sample spacing ", tag}, timing_bad, 0);
  endtask

  // raw symbol tail after sync; expects one error and no eop
  task automatic send_bad(bit low, int tail[$], string tag);
    bit bits[$];
    int syms[$];
    int stuffs;
    if (ls != low) set_speed(low);
    for (int i = 0; i < 7; i++) bits.push_back(1'b0);
    bits.push_back(1'b1);
    encode(bits, 1'b1, syms, stuffs);
    foreach (tail[i]) syms.push_back(tail[i]);
    clear_mon();
    foreach (syms[i]) drive(syms[i], 1);
    drive(S_SE0, 2);
    drive(S_J, 4);
    check(n_err == 1, {"R7 error pulse ", tag}, n_err, 1);
    check(n_eop == 0, {"R7 no eop ", tag}, n_eop, 0);
  endtask

  initial begin
    byte unsigned d[$];
    int seed;
    int k7[$];
    seed = $urandom(32'd2024);
    {dp, dm} = pins(S_J, 1'b0);
    repeat (3) @(negedge clk);
    check({bv, st, sop, eop, err} == 5'b0, "R8 reset outputs", {bv, st, sop, eop, err}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check({bv, st, sop, eop, err} == 5'b0, "R8 idle outputs", {bv, st, sop, eop, err}, 0);

    for (int p = 0; p < 4; p++) begin
      d.delete();
      for (int i = 0; i < 3 + p; i++) d.push_back(8'($urandom()));
      send_pkt(1'b0, d, "fs random");
    end
    d = '{8'hFF, 8'hFF, 8'h3F};
    send_pkt(1'b0, d, "fs all ones");
    d = '{8'hBF, 8'h7E};
    send_pkt(1'b0, d, "fs six ones then zero");
    for (int p = 0; p < 2; p++) begin
      d.delete();
      for (int i = 0; i < 2; i++) d.push_back(8'($urandom()));
      send_pkt(1'b1, d, "ls random");
    end
    d = '{8'hFF, 8'h01};
    send_pkt(1'b1, d, "ls all ones");

    // seventh one: K line after sync held for 7 more bit times
    k7.delete();
    for (int i = 0; i < 7; i++) k7.push_back(S_K);
    send_bad(1'b0, k7, "fs seventh one");
    send_bad(1'b0, '{S_J, S_SE1}, "fs se1 in packet");
    send_bad(1'b1, '{S_J, S_SE0, S_K}, "ls k during eop");
    send_bad(1'b0, '{S_SE0, S_SE1}, "fs se1 during eop");

    d = '{8'hA5};
    send_pkt(1'b0, d, "fs after errors");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule